// File: doc/BRIEF.md
# PCI Target Line Prefetcher

This block manages the single-line read buffer of a PCI target that hands system-memory data to a PCI master. It works one 32-byte cache line at a time. A read starts at the word named by the request address. It runs to the end of that line and then disconnects. A read that misses the buffer first fetches its line from memory.

While a read is in progress, the block can look ahead to the next sequential line. It asks the snoop port whether that line is held modified elsewhere. Once the snoop reports clean and the current read has finished, it loads the next line into the buffer. A follow-on read to that line is then served straight from the buffer, and that read can start the same look-ahead for the line after it. A read to any other line discards the buffered data.

The look-ahead runs when the enable bit is set, for any memory read command. A multiple-line read command starts it regardless of the enable bit. It never runs past a 4 KB page.

Top module: `pci_line_prefetcher`

## Requirements
- R1: While reset is held, reqReady is 1 and dataValid, memReq and snpReq are 0.
- R2: A read accepted at word offset k (reqAddr bits [4:2]) returns words k through 7 of its line in order, one per cycle with dataValid and mstReady both high. dataLast is high exactly on word 7. dataValid is low in the cycle after that word is taken.
- R3: When the look-ahead is wanted, snpReq rises in the cycle after the first word whose line index is 2 or higher has been taken. snpAddr is the next line's byte address (current line address + 32). snpReq and snpAddr hold until snpAck.
- R4: With cfgPrefetchEn low, a read using command 2'b00 (plain read), 2'b01 (line read) or 2'b11 (treated as plain read) starts no snoop and no look-ahead fetch.
- R5: Command 2'b10 (multiple-line read) starts the look-ahead even with cfgPrefetchEn low. With cfgPrefetchEn high, every command starts it.
- R6: The look-ahead fetch raises memReq with memAddr set to the next line's address. This happens only after snpAck has arrived with snpDirty low and after the last word of the current read has been taken.
- R7: A snoop answered with snpDirty high cancels the look-ahead: no memory fetch follows. A later read to that line fetches it from memory.
- R8: A read to the line held by a completed look-ahead returns the correct data without raising memReq. Its own look-ahead can fetch the following line.
- R9: A read to a line other than the buffered one discards the buffer and fetches its own line. A later read to the discarded line fetches it again from memory.
- R10: When the current line is the last 32-byte line of its 4 KB page, no snoop and no look-ahead fetch are started.
- R11: reqReady is high only when the block is idle: no data beat, no pending memory request and no pending snoop.
- R12: A read that misses the buffer raises memReq with memAddr equal to the request's line-aligned address. memReq and memAddr hold until memAck. Request addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPrefetchEn | input | 1 | Enables look-ahead for all read commands |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Request accepted on this cycle when high |
| reqAddr | input | 32 | Byte address of the first word to read |
| reqCmd | input | 2 | Read command: 00 plain, 01 line, 10 multiple-line, 11 plain |
| mstReady | input | 1 | Master takes the current data word |
| dataValid | output | 1 | Data word presented |
| dataWord | output | 32 | Data word |
| dataLast | output | 1 | Final word of the line; disconnect follows |
| snpReq | output | 1 | Snoop request for the look-ahead line |
| snpAddr | output | 32 | Line address being snooped |
| snpAck | input | 1 | Snoop response valid |
| snpDirty | input | 1 | Snooped line is held modified |
| memReq | output | 1 | Line fetch request |
| memAddr | output | 32 | Line address to fetch |
| memAck | input | 1 | Fetch request accepted |
| memRetValid | input | 1 | Returned data word valid (8 per line, in order) |
| memRetData | input | 32 | Returned data word |

## Verification
The hardest case to reach from the ports is the ordering race in the look-ahead. The snoop answer may come back while words are still flowing, or only after the read has disconnected. The fetch must wait for whichever comes last. To cover both orders, the stimulus sweeps every start offset, command and enable value, and varies the snoop latency, the memory latency and a toggling master-ready pattern across the sweep. In every case the bench timestamps the snoop answer, the final word and the fetch request. A second read to the next line then shows at the ports whether the buffer was really filled: it either raises a memory request or it does not.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SERVE,
    ST_POST,
    ST_PFETCH
  } ctlState_e;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_LINE  = 2'b01,
    CMD_MULTI = 2'b10,
    CMD_RSVD  = 2'b11
  } rdCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;      // capture a new request
    logic fillBeat;    // write one returned word
    logic fillDemand;  // demand line complete
    logic fillPf;      // look-ahead line complete
    logic beatAdv;     // advance read pointer
    logic armPf;       // latch next-line address
    logic dropBuf;     // invalidate before look-ahead load
  } dpStrobe_t;

endpackage

// File: rtl/pfb_datapath.sv
module pfb_datapath
  import pfb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int TRIG_WORD  = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobe_t                          stb,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] reqWord,
  input  logic [DATA_W-1:0]                  memRetData,
  input  logic                               fetchPf,
  output logic                               hit,
  output logic                               trigOk,
  output logic                               lastWord,
  output logic                               fillLast,
  output logic                               pageEnd,
  output logic [DATA_W-1:0]                  dataWord,
  output logic [ADDR_W-1:0]                  memAddr,
  output logic [ADDR_W-1:0]                  snpAddr
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int LINE_W     = ADDR_W - LINE_SHIFT;
  localparam int INPAGE_W   = PAGE_SHIFT - LINE_SHIFT;
  localparam int WADDR_W    = ADDR_W - BYTE_W;

  logic [DATA_W-1:0] lineBuf [LINE_WORDS];
  logic [LINE_W-1:0] curLine, pfLine, bufTag;
  logic              bufValid;
  logic [OFF_W-1:0]  rdPtr, fillCnt;

  logic [LINE_W-1:0] reqLine;
  logic [OFF_W-1:0]  reqOff;
  logic [LINE_W-1:0] fetchLine;

  assign reqLine = reqWord[WADDR_W-1:OFF_W];
  assign reqOff  = reqWord[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLine  <= '0;
      pfLine   <= '0;
      bufTag   <= '0;
      bufValid <= 1'b0;
      rdPtr    <= '0;
      fillCnt  <= '0;
    end else begin
      if (stb.accept) begin
        curLine <= reqLine;
        rdPtr   <= reqOff;
        fillCnt <= '0;
        if (!hit) bufValid <= 1'b0;
      end
      if (stb.dropBuf) begin
        bufValid <= 1'b0;
        fillCnt  <= '0;
      end
      if (stb.fillBeat)   fillCnt <= fillCnt + 1'b1;
      if (stb.fillDemand) begin
        bufValid <= 1'b1;
        bufTag   <= curLine;
      end
      if (stb.fillPf) begin
        bufValid <= 1'b1;
        bufTag   <= pfLine;
      end
      if (stb.beatAdv) rdPtr  <= rdPtr + 1'b1;
      if (stb.armPf)   pfLine <= curLine + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < LINE_WORDS; w++) begin
      if (stb.fillBeat && fillCnt == OFF_W'(w)) lineBuf[w] <= memRetData;
    end
  end

  assign hit       = bufValid && (bufTag == reqLine);
  assign trigOk    = rdPtr >= OFF_W'(TRIG_WORD);
  assign lastWord  = rdPtr == OFF_W'(LINE_WORDS - 1);
  assign fillLast  = fillCnt == OFF_W'(LINE_WORDS - 1);
  assign pageEnd   = &curLine[INPAGE_W-1:0];
  assign dataWord  = lineBuf[rdPtr];
  assign fetchLine = fetchPf ? pfLine : curLine;
  assign memAddr   = {fetchLine, {LINE_SHIFT{1'b0}}};
  assign snpAddr   = {pfLine, {LINE_SHIFT{1'b0}}};

endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgPrefetchEn,
  input  logic       reqValid,
  input  logic [1:0] reqCmd,
  input  logic       mstReady,
  input  logic       memAck,
  input  logic       memRetValid,
  input  logic       snpAck,
  input  logic       snpDirty,
  input  logic       hit,
  input  logic       trigOk,
  input  logic       lastWord,
  input  logic       fillLast,
  input  logic       pageEnd,
  output dpStrobe_t  stb,
  output logic       reqReady,
  output logic       dataValid,
  output logic       dataLast,
  output logic       memReq,
  output logic       snpReq,
  output logic       fetchPf
);
  ctlState_e state, stateNxt;
  logic memAcked, snpPend, snpClean, armed, pfWanted;
  logic inFetch, xfer;

  assign inFetch   = (state == ST_FETCH) || (state == ST_PFETCH);
  assign reqReady  = state == ST_IDLE;
  assign dataValid = state == ST_SERVE;
  assign dataLast  = dataValid && lastWord;
  assign memReq    = inFetch && !memAcked;
  assign snpReq    = snpPend;
  assign fetchPf   = state == ST_PFETCH;
  assign xfer      = dataValid && mstReady;

  always_comb begin
    stb            = '0;
    stb.accept     = reqReady && reqValid;
    stb.fillBeat   = inFetch && memRetValid;
    stb.fillDemand = (state == ST_FETCH) && memRetValid && fillLast;
    stb.fillPf     = (state == ST_PFETCH) && memRetValid && fillLast;
    stb.beatAdv    = xfer && !lastWord;
    stb.armPf      = xfer && trigOk && pfWanted && !armed && !pageEnd;
    stb.dropBuf    = (state == ST_POST) && snpClean;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (stb.accept) stateNxt = hit ? ST_SERVE : ST_FETCH;
      ST_FETCH:  if (stb.fillDemand) stateNxt = ST_SERVE;
      ST_SERVE:  if (xfer && lastWord) stateNxt = (armed || stb.armPf) ? ST_POST : ST_IDLE;
      ST_POST: begin
        if (snpClean)      stateNxt = ST_PFETCH;
        else if (!snpPend) stateNxt = ST_IDLE;
      end
      ST_PFETCH: if (stb.fillPf) stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      memAcked <= 1'b0;
      snpPend  <= 1'b0;
      snpClean <= 1'b0;
      armed    <= 1'b0;
      pfWanted <= 1'b0;
    end else begin
      state <= stateNxt;
      if (stb.accept || stb.dropBuf) memAcked <= 1'b0;
      else if (memReq && memAck)     memAcked <= 1'b1;
      if (stb.accept) begin
        armed    <= 1'b0;
        pfWanted <= cfgPrefetchEn || (reqCmd == CMD_MULTI);
      end
      if (stb.armPf) begin
        armed   <= 1'b1;
        snpPend <= 1'b1;
      end else if (snpPend && snpAck) begin
        snpPend  <= 1'b0;
        snpClean <= !snpDirty;
      end
      if (stb.dropBuf) snpClean <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_line_prefetcher.sv
module pci_line_prefetcher
  import pfb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int TRIG_WORD  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgPrefetchEn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqCmd,
  input  logic              mstReady,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataWord,
  output logic              dataLast,
  output logic              snpReq,
  output logic [ADDR_W-1:0] snpAddr,
  input  logic              snpAck,
  input  logic              snpDirty,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic              memRetValid,
  input  logic [DATA_W-1:0] memRetData
);
  localparam int BYTE_W = $clog2(DATA_W / 8);

  dpStrobe_t stb;
  logic hit, trigOk, lastWord, fillLast, pageEnd, fetchPf;

  pfb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgPrefetchEn(cfgPrefetchEn),
    .reqValid(reqValid), .reqCmd(reqCmd), .mstReady(mstReady),
    .memAck(memAck), .memRetValid(memRetValid),
    .snpAck(snpAck), .snpDirty(snpDirty),
    .hit(hit), .trigOk(trigOk), .lastWord(lastWord),
    .fillLast(fillLast), .pageEnd(pageEnd),
    .stb(stb), .reqReady(reqReady), .dataValid(dataValid),
    .dataLast(dataLast), .memReq(memReq), .snpReq(snpReq),
    .fetchPf(fetchPf)
  );

  pfb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .TRIG_WORD(TRIG_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqWord(reqAddr[ADDR_W-1:BYTE_W]), .memRetData(memRetData),
    .fetchPf(fetchPf), .hit(hit), .trigOk(trigOk), .lastWord(lastWord),
    .fillLast(fillLast), .pageEnd(pageEnd), .dataWord(dataWord),
    .memAddr(memAddr), .snpAddr(snpAddr)
  );

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              mstReady,
  input logic              dataValid,
  input logic              dataLast,
  input logic              snpReq,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpAck,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int BYTE_W     = $clog2(DATA_W / 8);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!dataValid && !memReq && !snpReq));

  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataLast |-> dataValid);

  // R2
  disconnect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && mstReady && dataLast) |=> !dataValid);

  // R10
  page_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpReq |-> (snpAddr[PAGE_SHIFT-1:0] != '0));

  // R6
  fetch_after_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> !snpReq);

  // R3
  snp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpReq && !snpAck) |=> (snpReq && $stable(snpAddr)));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R12
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> (reqAddr[BYTE_W-1:0] == '0));

endmodule

bind pci_line_prefetcher pfb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .mstReady(mstReady), .dataValid(dataValid),
  .dataLast(dataLast), .snpReq(snpReq), .snpAddr(snpAddr),
  .snpAck(snpAck), .memReq(memReq), .memAddr(memAddr), .memAck(memAck)
);

// File: tb/sim_pci_line_prefetcher.sv
module sim_pci_line_prefetcher;
  logic        clk, rstN, cfgPrefetchEn, reqValid, reqReady, mstReady;
  logic [31:0] reqAddr, dataWord, snpAddr, memAddr, memRetData;
  logic [1:0]  reqCmd;
  logic        dataValid, dataLast, snpReq, snpAck, snpDirty;
  logic        memReq, memAck, memRetValid;

  pci_line_prefetcher u0 (
    .clk(clk), .rstN(rstN), .cfgPrefetchEn(cfgPrefetchEn),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .mstReady(mstReady), .dataValid(dataValid),
    .dataWord(dataWord), .dataLast(dataLast), .snpReq(snpReq),
    .snpAddr(snpAddr), .snpAck(snpAck), .snpDirty(snpDirty),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memRetValid(memRetValid), .memRetData(memRetData)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int memLat = 1, snpLat = 1;
  bit dirtyCfg = 0, stallMode = 0;

  int cyc = 0, memRises, snpRises, readBeats, beatsAtSnp;
  int snpAckCyc, memRiseCyc, lastBeatCyc;
  logic [31:0] lastMemAddr, lastSnpAddr;
  logic memPrev = 0, snpPrev = 0;

  function automatic logic [31:0] wordOf(logic [31:0] lineAddr, int i);
    return lineAddr ^ (32'h0101_0101 * 32'(i)) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [31:0] lineAt(int l);
    return 32'(l) << 5;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  // master ready pattern
  initial begin
    mstReady = 1'b1;
    forever begin
      @(negedge clk);
      mstReady = stallMode ? ~mstReady : 1'b1;
    end
  end

  // memory model
  initial begin
    memAck = 0; memRetValid = 0; memRetData = '0;
    forever begin
      @(negedge clk);
      if (memReq) begin
        automatic logic [31:0] a = memAddr;
        repeat (memLat) @(negedge clk);
        memAck = 1'b1;
        @(negedge clk);
        memAck = 1'b0;
        for (int i = 0; i < 8; i++) begin
          memRetValid = 1'b1;
          memRetData  = wordOf(a, i);
          @(negedge clk);
        end
        memRetValid = 1'b0;
      end
    end
  end

  // snoop model
  initial begin
    snpAck = 0; snpDirty = 0;
    forever begin
      @(negedge clk);
      if (snpReq) begin
        repeat (snpLat) @(negedge clk);
        snpAck = 1'b1; snpDirty = dirtyCfg;
        @(negedge clk);
        snpAck = 1'b0; snpDirty = 1'b0;
      end
    end
  end

  // port monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      cyc++;
      if (memReq && !memPrev) begin memRises++; lastMemAddr = memAddr; memRiseCyc = cyc; end
      if (snpReq && !snpPrev) begin snpRises++; lastSnpAddr = snpAddr; beatsAtSnp = readBeats; end
      if (snpReq && snpAck) snpAckCyc = cyc;
      if (dataValid && mstReady) begin
        readBeats++;
        if (dataLast) lastBeatCyc = cyc;
      end
      memPrev = memReq; snpPrev = snpReq;
    end
  end

  task automatic waitIdle();
    while (!reqReady) tick();
  endtask

  task automatic doRead(int l, int off, logic [1:0] cmd, bit en, string req);
    int idx;
    waitIdle();
    memRises = 0; snpRises = 0; readBeats = 0; beatsAtSnp = -1;
    cfgPrefetchEn = en;
    reqAddr  = lineAt(l) | (32'(off) << 2);
    reqCmd   = cmd;
    reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
    chk(!reqReady, "R11", "busy after accept", 32'(reqReady), 0);
    idx = off;
    while (idx < 8) begin
      if (dataValid && mstReady) begin
        chk(dataWord == wordOf(lineAt(l), idx), req, "data word", dataWord, wordOf(lineAt(l), idx));
        chk(dataLast == (idx == 7), "R2", "last flag", 32'(dataLast), 32'(idx == 7));
        idx++;
      end
      tick();
    end
    chk(!dataValid, "R2", "disconnect after line end", 32'(dataValid), 0);
  endtask

  initial begin
    rstN = 0; reqValid = 0; reqAddr = '0; reqCmd = '0; cfgPrefetchEn = 0;
    repeat (3) tick();
    // R1 reset state
    chk(reqReady && !dataValid && !memReq && !snpReq, "R1", "reset outputs",
        {28'd0, reqReady, dataValid, memReq, snpReq}, 32'h8);
    rstN = 1;
    tick();

    // sweep: offset x command x enable, varied latencies and stalls
    for (int k = 0; k < 64; k++) begin
      automatic int  off = k % 8;
      automatic int  cmd = (k / 8) % 4;
      automatic bit  en  = (k >= 32);
      automatic int  l   = 8 + 4 * k;
      automatic bit  pf  = en || (cmd == 2);
      automatic int  expBeats = (off <= 2) ? 3 - off : 1;
      snpLat = (k % 3 == 0) ? 12 : 1;
      memLat = k % 3;
      stallMode = (k % 2 == 1);
      doRead(l, off, 2'(cmd), en, "R2");
      waitIdle();
      chk(snpRises == int'(pf), pf ? "R5" : "R4", "snoop count", 32'(snpRises), 32'(pf));
      chk(memRises == 1 + int'(pf), pf ? "R6" : "R4", "fetch count", 32'(memRises), 32'(1 + int'(pf)));
      if (pf) begin
        chk(lastSnpAddr == lineAt(l + 1), "R3", "snoop address", lastSnpAddr, lineAt(l + 1));
        chk(beatsAtSnp == expBeats, "R3", "snoop start beat", 32'(beatsAtSnp), 32'(expBeats));
        chk(lastMemAddr == lineAt(l + 1), "R6", "look-ahead address", lastMemAddr, lineAt(l + 1));
        chk(memRiseCyc > snpAckCyc && memRiseCyc > lastBeatCyc, "R6", "fetch order",
            32'(memRiseCyc), 32'(snpAckCyc > lastBeatCyc ? snpAckCyc : lastBeatCyc) + 1);
      end
      doRead(l + 1, 0, 2'b00, 0, "R8");
      waitIdle();
      chk(memRises == (pf ? 0 : 1), pf ? "R8" : "R12", "follow-on fetch count",
          32'(memRises), pf ? 0 : 1);
      if (!pf) chk(lastMemAddr == lineAt(l + 1), "R12", "demand address", lastMemAddr, lineAt(l + 1));
    end
    stallMode = 0; snpLat = 2; memLat = 1;

    // R7 dirty snoop cancels
    dirtyCfg = 1;
    doRead(600, 0, 2'b00, 1, "R7");
    waitIdle(); repeat (10) tick();
    chk(snpRises == 1, "R7", "snoop issued", 32'(snpRises), 1);
    chk(memRises == 1, "R7", "no look-ahead fetch", 32'(memRises), 1);
    dirtyCfg = 0;
    doRead(601, 0, 2'b00, 0, "R7");
    waitIdle();
    chk(memRises == 1 && lastMemAddr == lineAt(601), "R7", "refetch after cancel", lastMemAddr, lineAt(601));

    // R9 mismatch discards
    doRead(700, 0, 2'b01, 1, "R9");
    doRead(705, 3, 2'b00, 0, "R9");
    waitIdle();
    chk(memRises == 1 && lastMemAddr == lineAt(705), "R9", "mismatch fetch", lastMemAddr, lineAt(705));
    doRead(701, 0, 2'b00, 0, "R9");
    waitIdle();
    chk(memRises == 1 && lastMemAddr == lineAt(701), "R9", "discarded line refetched", lastMemAddr, lineAt(701));

    // R10 page boundary
    doRead(127, 0, 2'b10, 1, "R10");
    waitIdle(); repeat (5) tick();
    chk(snpRises == 0 && memRises == 1, "R10", "no look-ahead at page end", 32'(snpRises), 0);
    doRead(255, 6, 2'b10, 1, "R10");
    waitIdle(); repeat (5) tick();
    chk(snpRises == 0 && memRises == 1, "R10", "no look-ahead at page end 2", 32'(snpRises), 0);
    doRead(126, 0, 2'b00, 1, "R10");
    waitIdle();
    chk(snpRises == 1 && lastSnpAddr == lineAt(127), "R10", "look-ahead inside page", lastSnpAddr, lineAt(127));

    // R8 chained look-ahead
    doRead(800, 0, 2'b00, 1, "R8");
    doRead(801, 0, 2'b00, 1, "R8");
    waitIdle();
    chk(memRises == 1 && lastMemAddr == lineAt(802), "R8", "chained fetch", lastMemAddr, lineAt(802));
    chk(memRiseCyc > lastBeatCyc, "R8", "no fetch during hit read", 32'(memRiseCyc), 32'(lastBeatCyc + 1));
    chk(lastSnpAddr == lineAt(802), "R8", "chained snoop", lastSnpAddr, lineAt(802));
    doRead(802, 4, 2'b01, 0, "R8");
    waitIdle();
    chk(memRises == 0, "R8", "chained hit", 32'(memRises), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule